// File: doc/BRIEF.md
# Base-2 Exponential Estimator (four-lane, pipelined)

This block returns an estimate of 2^x for IEEE-754 single-precision operands. Each lane unbiases the exponent and turns the operand into a signed fixed-point value with 23 fraction bits. The integer part of that value sets the result exponent. The top three fraction bits select one of eight stored powers 2^(k/8), and the remaining fraction bits refine the selected entry by a linear correction built from two multiply-high steps. Very large and very small magnitudes, NaN operands, overflow and results in the denormal range each have a fixed rule.

The top instance applies the same function to every 32-bit lane of a wide word. One valid bit qualifies all lanes, and the result leaves a configurable number of register stages later with a matching strobe. Lane k occupies bits [32k+31:32k] on both the input bus and the output bus.

Top module: `exp2_vec_est`

## Requirements
- R1: An operand with exponent field 255 and a non-zero fraction produces the operand with bit 22 forced to 1.
- R2: An operand whose unbiased exponent exceeds 7 and that is not a NaN produces +0 (0x00000000) when bit 31 is set and +Inf (0x7F800000) when it is clear.
- R3: An operand whose unbiased exponent is below -23 (exponent field below 104) produces exactly 0x3F800000.
- R4: Otherwise the signed fixed value F is the 24-bit significand shifted by the unbiased exponent and negated for a negative operand. E = (F >>> 23) + 126. The mantissa is T[F[22:20]] plus the high word of (high word of ((F<<12) mod 2^32) * 0x172B83FF) * T[...]. T is 0x800000, 0x8B95C2, 0x9837F0, 0xA5FED7, 0xB504F3, 0xC5672A, 0xD744FD, 0xEAC0C7. When 0 <= E < 254 the result is mantissa + (E << 23), with the hidden bit carried into the exponent field.
- R5: When E >= 254 the result is +Inf (0x7F800000).
- R6: When -23 <= E < 0 the result is (mantissa + (1 << (-E-1))) >> -E. When E < -23 the result is 0.
- R7: out_valid equals in_valid delayed by exactly STAGES clock cycles. A reset clears every valid bit in flight.
- R8: Each lane computes its result only from its own input lane.
- R9: Multiply-high keeps bits 63..32 of the full unsigned 32x32 product, with no rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | LANES*32 | Packed single-precision operands, lane 0 in the low bits |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | LANES*32 | Packed estimates of 2^x |

## Verification
Every result appears on the outputs exactly STAGES rising edges after the edge that accepted its operand. The bench tags each expected word with the cycle count at the time it was driven. The monitor samples on falling edges and checks that the cycle count has advanced by exactly STAGES when the word appears. A result that arrives with nothing pending, or at any other distance, is a failure. Valid bubbles, back-to-back beats and a reset with data in flight check that the timing does not depend on the traffic pattern.

// File: rtl/exp2_est_pkg.sv
// Package: constants and the power-of-two table shared by the lanes.
// Assumes: 32-bit single-precision words.
package exp2_est_pkg;

    localparam int WORD_W   = 32;
    localparam int FRAC_W   = 23;
    localparam logic [31:0] ONE_WORD  = 32'h3F80_0000;
    localparam logic [31:0] PINF_WORD = 32'h7F80_0000;
    localparam logic [31:0] QUIET_BIT = 32'h0040_0000;
    localparam logic [31:0] SLOPE_K   = 32'h172B_83FF;

    // 2^(k/8) scaled by 2^23, selected by the top three fraction bits
    function automatic logic [31:0] pow8_entry(input logic [2:0] k);
        case (k)
            3'd0:    pow8_entry = 32'h0080_0000;
            3'd1:    pow8_entry = 32'h008B_95C2;
            3'd2:    pow8_entry = 32'h0098_37F0;
            3'd3:    pow8_entry = 32'h00A5_FED7;
            3'd4:    pow8_entry = 32'h00B5_04F3;
            3'd5:    pow8_entry = 32'h00C5_672A;
            3'd6:    pow8_entry = 32'h00D7_44FD;
            default: pow8_entry = 32'h00EA_C0C7;
        endcase
    endfunction

    // upper word of a full unsigned 32x32 product, truncated (R9)
    function automatic logic [31:0] mul_hi(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] prod;
        prod   = {32'd0, a} * {32'd0, b};
        mul_hi = prod[63:32];
    endfunction

endpackage

// File: rtl/exp2_lane_eval.sv
// Module: combinational 2^x estimate for one lane.
// Assumes: input is a single-precision bit pattern; no registers inside.
module exp2_lane_eval
    import exp2_est_pkg::*;
(
    input  logic [31:0] x,
    output logic [31:0] y
);

    logic signed [9:0]  ue;       // unbiased operand exponent
    logic [23:0]        sig;      // significand with hidden bit
    logic [31:0]        mag;      // |x| as fixed point, 23 fraction bits
    logic [31:0]        fixv;     // signed fixed value
    logic signed [9:0]  re;       // result exponent
    logic [31:0]        base;     // table entry
    logic [31:0]        step;     // first multiply-high
    logic [31:0]        man;      // corrected mantissa
    logic [4:0]         dsh;      // denormal shift amount
    logic [31:0]        dres;     // denormal result
    logic               is_nan;
    logic [6:0]         rsh;      // right shift for negative exponents

    // build fixed value, exponent, table lookup and correction
    always_comb begin
        ue     = $signed({2'b00, x[30:23]}) - 10'sd127;
        sig    = {1'b1, x[22:0]};
        is_nan = (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
        rsh    = 7'(-ue);
        if (ue > 10'sd0)
            mag = {8'd0, sig} << ue[2:0];
        else
            mag = {8'd0, sig} >> rsh;
        fixv = x[31] ? (32'd0 - mag) : mag;
        re   = $signed({fixv[31], fixv[31:23]}) + 10'sd126;
        base = pow8_entry(fixv[22:20]);
        step = mul_hi({fixv[19:0], 12'd0}, SLOPE_K);
        man  = base + mul_hi(step, base);
        dsh  = 5'(-re);
        dres = (man + (32'd1 << (dsh - 5'd1))) >> dsh;
    end

    // select the result by operand and exponent class
    always_comb begin
        if (ue > 10'sd7) begin
            if (is_nan)
                y = x | QUIET_BIT;
            else
                y = x[31] ? 32'd0 : PINF_WORD;
        end else if (ue < -10'sd23) begin
            y = ONE_WORD;
        end else if (re >= 10'sd254) begin
            y = PINF_WORD;
        end else if (re < -10'sd23) begin
            y = 32'd0;
        end else if (re >= 10'sd0) begin
            y = man + ({24'd0, re[7:0]} << FRAC_W);
        end else begin
            y = dres;
        end
    end

endmodule

// File: rtl/exp2_delay_pipe.sv
// Module: STAGES-deep register line for a data word and its valid bit.
// Assumes: STAGES >= 0; data registers are not reset, valid bits are.
module exp2_delay_pipe #(
    parameter int W      = 128,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         i_vld,
    input  logic [W-1:0] i_dat,
    output logic         o_vld,
    output logic [W-1:0] o_dat
);

    localparam int CNT_W = $clog2(STAGES + 2);

    generate
        if (STAGES == 0) begin : g_pass
            assign o_vld = i_vld;
            assign o_dat = i_dat;
        end else begin : g_regs
            logic [STAGES-1:0] vld_q;
            logic [W-1:0]      dat_q [STAGES];

            // valid shift chain, cleared by reset
            always_ff @(posedge clk) begin
                if (!rst_n) vld_q <= '0;
                else        vld_q <= {vld_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], i_vld} & {STAGES{1'b1}};
            end

            for (genvar s = 0; s < STAGES; s++) begin : g_st
                // data stage s loads from its predecessor
                always_ff @(posedge clk) begin
                    if (s == 0) dat_q[s] <= i_dat;
                    else        dat_q[s] <= dat_q[(s == 0) ? 0 : s-1];
                end
            end

            assign o_vld = vld_q[STAGES-1];
            assign o_dat = dat_q[STAGES-1];
        end
    endgenerate

    // count of beats accepted but not yet delivered
    logic [CNT_W-1:0] inflight;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CNT_W'(i_vld) - CNT_W'(o_vld);
    end

    assert_no_orphan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && STAGES > 0) |-> (inflight != '0));
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(STAGES));

endmodule

// File: rtl/exp2_vec_est.sv
// Module: top; LANES copies of the lane evaluator feeding one delay pipe.
// Assumes: a single valid bit covers all lanes; latency is STAGES cycles.
module exp2_vec_est
    import exp2_est_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*WORD_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_data
);

    localparam int BUS_W = LANES * WORD_W;

    logic [BUS_W-1:0] lane_res;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [31:0] lx;
            logic [31:0] ly;
            assign lx = in_data[l*WORD_W +: WORD_W];

            exp2_lane_eval u_eval (
                .x (lx),
                .y (ly)
            );

            assign lane_res[l*WORD_W +: WORD_W] = ly;

            assert_nan_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && lx[30:23] == 8'hFF && lx[22:0] != 23'd0) |-> (ly == (lx | QUIET_BIT)));
            assert_big_mag_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && lx[30:23] >= 8'd135 && !(lx[30:23] == 8'hFF && lx[22:0] != 23'd0))
                |-> (ly == (lx[31] ? 32'd0 : PINF_WORD)));
            assert_tiny_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && lx[30:23] < 8'd104) |-> (ly == ONE_WORD));
            assert_sign_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !(lx[30:23] == 8'hFF && lx[22:0] != 23'd0)) |-> !ly[31]);
        end
    endgenerate

    exp2_delay_pipe #(
        .W      (BUS_W),
        .STAGES (STAGES)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .i_vld (in_valid),
        .i_dat (lane_res),
        .o_vld (out_valid),
        .o_dat (out_data)
    );

endmodule

// File: tb/tb_exp2_vec_est.sv
module tb_exp2_vec_est;

    localparam int LANES  = 4;
    localparam int STAGES = 2;
    localparam int BW     = LANES * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic          out_valid;
    logic [BW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [BW-1:0] exp;
        int            cyc;
        string         tag;
    } item_t;
    item_t sb[$];

    exp2_vec_est #(.LANES(LANES), .STAGES(STAGES)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;   // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // reference estimate written from the requirements
    function automatic logic [31:0] model(input logic [31:0] s);
        int e, ie, sh;
        longint p;
        longint unsigned m, f, t;
        e = int'(s[30:23]) - 127;
        if (e > 7) begin
            if (s[30:23] == 8'hFF && s[22:0] != 0) return s | 32'h0040_0000;
            return s[31] ? 32'h0 : 32'h7F80_0000;
        end
        if (e < -23) return 32'h3F80_0000;
        p = longint'({1'b1, s[22:0]});
        if (e > 0) p = p << e; else p = p >> (-e);
        if (s[31]) p = -p;
        ie = int'(p >>> 23) + 126;
        if (ie >= 254) return 32'h7F80_0000;
        if (ie < -23) return 32'h0;
        case ((p >> 20) & 7)
            0: m = 64'h800000; 1: m = 64'h8B95C2; 2: m = 64'h9837F0; 3: m = 64'hA5FED7;
            4: m = 64'hB504F3; 5: m = 64'hC5672A; 6: m = 64'hD744FD; default: m = 64'hEAC0C7;
        endcase
        t = longint'(unsigned'(p << 12)) & 64'hFFFF_FFFF;       // R9
        f = (t * 64'h172B_83FF) >> 32;
        f = (f * m) >> 32;
        m = m + f;
        if (ie >= 0) return 32'(m + (longint'(ie) << 23));
        sh = -ie;
        return 32'((m + (64'd1 << (sh - 1))) >> sh);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // driver: one beat at the falling edge, expected word to the scoreboard
    task automatic send(input logic [BW-1:0] v, input logic [BW-1:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        it.exp = exp; it.cyc = cyc; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic send_model(input logic [BW-1:0] v, input string tag);
        logic [BW-1:0] e;
        for (int l = 0; l < LANES; l++) e[l*32 +: 32] = model(v[l*32 +: 32]);
        send(v, e, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = '0;
        end
    endtask

    // monitor: compare each delivered beat, including its latency (R7)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(cyc - it.cyc == STAGES, "R7 latency", 32'(cyc - it.cyc), 32'(STAGES));
                for (int l = 0; l < LANES; l++)
                    check(out_data[l*32 +: 32] === it.exp[l*32 +: 32], it.tag,
                          out_data[l*32 +: 32], it.exp[l*32 +: 32]);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R7 reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // R1 NaN, R2 large magnitude, infinities
        send({32'hFF80_0010, 32'h7F80_0000, 32'hC380_0000, 32'h7F80_0001},
             {32'hFFC0_0010, 32'h7F80_0000, 32'h0000_0000, 32'h7FC0_0001}, "R1/R2 nan big");
        send({32'hFF80_0000, 32'h4380_0000, 32'h7FC0_1234, 32'hC3FF_0000},
             {32'h0000_0000, 32'h7F80_0000, 32'h7FC0_1234, 32'h0000_0000}, "R2 big sign R1 quiet");
        // R3 tiny operands, both signs and zero
        send({32'h8000_0000, 32'h3300_0000, 32'hB300_0000, 32'h0000_0000},
             {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, "R3 tiny");
        // R4 exact powers and table points, R9 correction
        send({32'h3D80_0000, 32'hBF80_0000, 32'h3F00_0000, 32'h3F80_0000},
             {32'h3F85_CAE0, 32'h3F00_0000, 32'h3FB5_04F3, 32'h4000_0000}, "R4 R9 normal");
        // R5 overflow at result exponent 254, just below
        send({32'h42FE_0000, 32'h4300_0000, 32'h4100_0000, 32'h42FC_0000},
             {model(32'h42FE_0000), 32'h7F80_0000, 32'h4380_0000, model(32'h42FC_0000)}, "R5 overflow edge");
        // R6 denormal outputs and flush
        send({32'hC316_0000, 32'hC315_0000, 32'hC2FE_0000, 32'hC300_0000},
             {32'h0000_0000, 32'h0000_0001, 32'h0040_0000, 32'h0020_0000}, "R6 denormal");
        idle(2);

        // R8 lanes independent: one interesting lane among constant neighbours
        for (int l = 0; l < LANES; l++) begin
            logic [BW-1:0] v;
            logic [BW-1:0] e;
            v = {LANES{32'h3F80_0000}};
            e = {LANES{32'h4000_0000}};
            v[l*32 +: 32] = 32'h3F00_0000;
            e[l*32 +: 32] = 32'h3FB5_04F3;
            send(v, e, "R8 lane isolation");
        end

        // random sweep with bubbles (R4 R5 R6 R7)
        for (int i = 0; i < 300; i++) begin
            logic [BW-1:0] v;
            for (int l = 0; l < LANES; l++) begin
                logic [31:0] w;
                w = $urandom;
                w[30:23] = 8'(100 + ($urandom % 40));
                v[l*32 +: 32] = w;
            end
            send_model(v, "R4/R6 random");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(STAGES + 2);

        // R7 reset with a beat in flight drops it
        send({LANES{32'h3F80_0000}}, '0, "R7 flushed");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0, "R7 reset clears", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        repeat (STAGES + 2) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R7 no ghost after reset", 32'(out_valid), 32'd0);
        end
        send({LANES{32'h3F80_0000}}, {LANES{32'h4000_0000}}, "R7 after reset");
        idle(STAGES + 3);
        check(sb.size() == 0, "R7 all delivered", 32'(sb.size()), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 32'd1, 32'd0);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule